// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer Pair

This block holds two 16-bit up-counting timers that share one 8-bit control byte. Each timer takes a tick source (the block clock, or the block clock divided by a fixed slow factor), runs it through two 8-bit dividers in series, and increments its counter once per divided tick. When a tick arrives while the counter equals the timer's compare value, a sticky flag is raised. The counter then either returns to zero or keeps counting past the compare value. The flag can drive that timer's interrupt line.

The second timer can instead be chained to the first. It then counts the first timer's rollovers, and the pair acts as one 32-bit counter compared against both compare values joined together. Software reaches every register over a plain single-cycle write and combinational read bus. A build parameter can remove the primary divider register, so that it reads as zero and divides by one.

Top module: `timer_pair`

## Requirements
- R1: After rst, every register reads 0 and both irq bits are 0.
- R2: With clock select 1 (mode bits [2:1]) and both dividers at 0, a running counter advances by one every clock. A tick that finds the counter equal to the compare value sets event bit 1. If mode bit 3 is set, that same tick loads the counter with 0, so the period is compare+1 ticks.
- R3: The counter advances once every (P+1)*(S+1) source ticks. P is the primary divider register (8 bits). S is mode bits [15:8].
- R4: Clock select 2 takes one source tick every 16 clocks. Clock select 3, and clock select 0 on timer 0, give no ticks.
- R5: With mode bit 3 clear, a compare match still sets event bit 1, and the counter goes on incrementing past the compare value and wraps at 0xFFFF.
- R6: Control bit 1 (timer 0) or bit 5 (timer 1) freezes that timer's counter and divider state. Clearing the bit resumes counting from the held state.
- R7: Writing 1 to control bit 0 (timer 0) or bit 4 (timer 1) sets the bit. On the next clock, that timer's counter, divider state and event register become 0, and the bit returns to 0. The other timer is not affected.
- R8: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. If a compare match falls in the same clock as a clearing write, the flag stays set.
- R9: Software can write the counter. A counter write in the same clock as a tick or a restart takes priority.
- R10: irq[i] is 1 exactly while timer i has event bit 1 set and mode bit 4 set. It stays 1 until the flag is cleared.
- R11: With timer 1 at clock select 0, timer 1 advances by one each time a tick takes timer 0 from 0xFFFF to 0. The pair is then compared as {count1,count0} against {compare1,compare0}. A match sets event bit 1 of timer 1 only, and if timer 1 mode bit 3 is set, both counters return to 0.
- R12: bus_addr[3:1] selects the register group: 0 control, 1 mode, 2 compare, 3 counter, 4 event, 5 primary divider. bus_addr[0] selects the timer. Writes take effect at the next clock and reads are combinational. Groups 6 and 7 read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address (group in [3:1], timer in [0]) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 2 | Per-timer interrupt request |

## Verification
A compare match that sets a timer's flag can land in the same clock as a software write that clears that flag. A counter write can also land in the same clock as a tick or a restart. The bench provokes both. It issues back-to-back clearing writes and back-to-back counter loads across a whole short compare period, so that every phase of the period is hit once. A behavioural model that keeps set-over-clear and load-over-count priority is compared with the register read-back and the interrupt lines on every clock.

// File: rtl/timer_pair_pkg.sv
package timer_pair_pkg;

    localparam int CNT_W  = 16;
    localparam int PSC_W  = 8;
    localparam int CFG_W  = 8;
    localparam int ADDR_W = 4;
    localparam int EVT_W  = 2;
    localparam int GRP_W  = ADDR_W - 1;
    localparam int EVT_REF_BIT = 1;

    typedef enum logic [1:0] {
        CLK_CASCADE  = 2'd0,
        CLK_INTERNAL = 2'd1,
        CLK_SLOW     = 2'd2,
        CLK_NONE     = 2'd3
    } clk_src_e;

    // mode word: [15:8] secondary divide, [4] irq enable, [3] restart, [2:1] source
    typedef struct packed {
        logic [PSC_W-1:0] sec_div;
        logic [2:0]       spare_hi;
        logic             irq_en;
        logic             restart;
        clk_src_e         src;
        logic             spare_lo;
    } mode_t;

    typedef enum logic [GRP_W-1:0] {
        GRP_CFG  = 3'd0,
        GRP_MODE = 3'd1,
        GRP_REF  = 3'd2,
        GRP_CNT  = 3'd3,
        GRP_EVT  = 3'd4,
        GRP_PSC  = 3'd5
    } reg_grp_e;

    function automatic int stop_bit(input int idx);
        return (idx % 2 == 1) ? 5 : 1;
    endfunction

    function automatic int reset_bit(input int idx);
        return (idx % 2 == 1) ? 4 : 0;
    endfunction

endpackage

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
    import timer_pair_pkg::*;
#(
    parameter int SLOW_DIV = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  clk_src_e         src,
    input  logic [PSC_W-1:0] pri_div,
    input  logic [PSC_W-1:0] sec_div,
    output logic             tick
);
    localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic [PSC_W-1:0] pri_q;
    logic [PSC_W-1:0] sec_q;
    logic             div_last;
    logic             src_tick;
    logic             pri_tick;

    always_comb begin
        div_last = (div_q == DIV_LAST);
        src_tick = run && ((src == CLK_INTERNAL) || ((src == CLK_SLOW) && div_last));
        pri_tick = src_tick && (pri_q == pri_div);
        tick     = pri_tick && (sec_q == sec_div);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q <= '0;
            pri_q <= '0;
            sec_q <= '0;
        end else begin
            if (run && (src == CLK_SLOW))
                div_q <= div_last ? '0 : div_q + 1'b1;
            if (src_tick)
                pri_q <= pri_tick ? '0 : pri_q + 1'b1;
            if (pri_tick)
                sec_q <= tick ? '0 : sec_q + 1'b1;
        end
    end

endmodule

// File: rtl/timer_count.sv
module timer_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         zero,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (zero)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/timer_pair.sv
module timer_pair
    import timer_pair_pkg::*;
#(
    parameter int SLOW_DIV    = 16,
    parameter bit HAS_PRIMARY = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [1:0]        irq
);
    localparam int NTMR = 2;

    logic [GRP_W-1:0] grp;
    logic             tsel;
    logic [CFG_W-1:0] cfg_q;

    mode_t            mode_v  [NTMR];
    logic [CNT_W-1:0] ref_v   [NTMR];
    logic [CNT_W-1:0] cnt_v   [NTMR];
    logic [EVT_W-1:0] evt_v   [NTMR];
    logic [PSC_W-1:0] psr_v   [NTMR];
    logic [NTMR-1:0]  stop_v;
    logic [NTMR-1:0]  rbit_v;
    logic [NTMR-1:0]  run_v;
    logic [NTMR-1:0]  gen_tick;
    logic [NTMR-1:0]  ev_set;
    logic [NTMR-1:0]  zero;
    logic [NTMR-1:0]  inc;
    logic             casc;
    logic             full_match;
    logic             wrap0;

    assign grp  = bus_addr[ADDR_W-1:1];
    assign tsel = bus_addr[0];

    // shared control byte; reset bits drop back to zero one clock after being set
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (bus_we && (grp == GRP_CFG)) begin
            cfg_q <= bus_wdata[CFG_W-1:0];
        end else begin
            cfg_q[reset_bit(0)] <= 1'b0;
            cfg_q[reset_bit(1)] <= 1'b0;
        end
    end

    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
        localparam int STOP_B = stop_bit(i);
        localparam int RST_B  = reset_bit(i);

        logic             hit;
        logic             wr_mode;
        logic             wr_ref;
        logic             wr_cnt;
        logic             wr_evt;
        logic             wr_psc;
        mode_t            mode_r;
        logic [CNT_W-1:0] ref_r;
        logic [EVT_W-1:0] evt_r;
        logic [EVT_W-1:0] w1c;

        assign hit     = bus_we && (tsel == 1'(i));
        assign wr_mode = hit && (grp == GRP_MODE);
        assign wr_ref  = hit && (grp == GRP_REF);
        assign wr_cnt  = hit && (grp == GRP_CNT);
        assign wr_evt  = hit && (grp == GRP_EVT);
        assign wr_psc  = hit && (grp == GRP_PSC);

        assign stop_v[i] = cfg_q[STOP_B];
        assign rbit_v[i] = cfg_q[RST_B];
        assign run_v[i]  = !cfg_q[STOP_B] && !cfg_q[RST_B];

        always_ff @(posedge clk) begin
            if (rst) begin
                mode_r <= '0;
                ref_r  <= '0;
            end else begin
                if (wr_mode) mode_r <= mode_t'(bus_wdata);
                if (wr_ref)  ref_r  <= bus_wdata;
            end
        end

        if (HAS_PRIMARY) begin : g_psc
            logic [PSC_W-1:0] psr_r;
            always_ff @(posedge clk) begin
                if (rst)
                    psr_r <= '0;
                else if (wr_psc)
                    psr_r <= bus_wdata[PSC_W-1:0];
            end
            assign psr_v[i] = psr_r;
        end else begin : g_no_psc
            assign psr_v[i] = '0;
        end

        assign w1c = wr_evt ? bus_wdata[EVT_W-1:0] : '0;

        // a new match outranks a clearing write landing in the same clock
        always_ff @(posedge clk) begin
            if (rst || rbit_v[i])
                evt_r <= '0;
            else
                evt_r <= (evt_r & ~w1c) | (EVT_W'(ev_set[i]) << EVT_REF_BIT);
        end

        assign mode_v[i] = mode_r;
        assign ref_v[i]  = ref_r;
        assign evt_v[i]  = evt_r;
        assign irq[i]    = evt_r[EVT_REF_BIT] && mode_r.irq_en;

        timer_tick_gen #(
            .SLOW_DIV (SLOW_DIV)
        ) u_tick (
            .clk     (clk),
            .rst     (rst),
            .clr     (rbit_v[i]),
            .run     (run_v[i]),
            .src     (mode_r.src),
            .pri_div (psr_v[i]),
            .sec_div (mode_r.sec_div),
            .tick    (gen_tick[i])
        );

        timer_count #(
            .W (CNT_W)
        ) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .clr      (rbit_v[i]),
            .load     (wr_cnt),
            .load_val (bus_wdata),
            .zero     (zero[i]),
            .inc      (inc[i]),
            .cnt      (cnt_v[i])
        );
    end

    // compare, restart and chaining
    always_comb begin
        casc       = (mode_v[1].src == CLK_CASCADE);
        full_match = ({cnt_v[1], cnt_v[0]} == {ref_v[1], ref_v[0]});
        ev_set     = '0;
        zero       = '0;
        inc        = '0;
        wrap0      = 1'b0;
        if (casc) begin
            ev_set[1] = gen_tick[0] && full_match;
            zero      = {NTMR{ev_set[1] && mode_v[1].restart}};
            inc[0]    = gen_tick[0];
            wrap0     = gen_tick[0] && (cnt_v[0] == '1) && !zero[0];
            inc[1]    = wrap0 && run_v[1];
        end else begin
            for (int k = 0; k < NTMR; k++) begin
                ev_set[k] = gen_tick[k] && (cnt_v[k] == ref_v[k]);
                zero[k]   = ev_set[k] && mode_v[k].restart;
                inc[k]    = gen_tick[k];
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (grp)
            GRP_CFG:  bus_rdata = {{(CNT_W-CFG_W){1'b0}}, cfg_q};
            GRP_MODE: bus_rdata = mode_v[tsel];
            GRP_REF:  bus_rdata = ref_v[tsel];
            GRP_CNT:  bus_rdata = cnt_v[tsel];
            GRP_EVT:  bus_rdata = {{(CNT_W-EVT_W){1'b0}}, evt_v[tsel]};
            GRP_PSC:  bus_rdata = {{(CNT_W-PSC_W){1'b0}}, psr_v[tsel]};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/timer_pair_chk.sv
module timer_pair_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_we,
    input logic [3:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [1:0]  irq,
    input logic [7:0]  cfg,
    input logic [15:0] cnt0,
    input logic [15:0] ref0,
    input logic [1:0]  evt0,
    input logic        ev_set0,
    input logic        tick0,
    input logic        restart0,
    input logic        casc
);
    logic wr_cfg;
    logic wr_cnt0;
    logic wr_evt0;
    logic wr_mode0;

    assign wr_cfg   = bus_we && (bus_addr[3:1] == 3'd0);
    assign wr_cnt0  = bus_we && (bus_addr == 4'd6);
    assign wr_evt0  = bus_we && (bus_addr == 4'd8);
    assign wr_mode0 = bus_we && (bus_addr == 4'd2);

    AST_RESTART_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!casc && restart0 && tick0 && (cnt0 == ref0) && !cfg[0] && !wr_cnt0) |=> (cnt0 == 16'd0)); // R2

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cfg[1] && !cfg[0] && !wr_cnt0) |=> (cnt0 == $past(cnt0))); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cfg[0] |=> ((cnt0 == 16'd0) && (evt0 == 2'd0))); // R7

    AST_RESET_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cfg[0] && !wr_cfg) |=> !cfg[0]); // R7

    AST_EVT_W1C: assert property (@(posedge clk) disable iff (rst)
        (wr_evt0 && bus_wdata[1] && !ev_set0) |=> !evt0[1]); // R8

    AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (ev_set0 && !cfg[0]) |=> evt0[1]); // R8

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt0 && !cfg[0]) |=> (cnt0 == $past(bus_wdata))); // R9

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq[0] && !cfg[0] && !wr_evt0 && !wr_mode0) |=> irq[0]); // R10

endmodule

bind timer_pair timer_pair_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .cfg       (cfg_q),
    .cnt0      (cnt_v[0]),
    .ref0      (ref_v[0]),
    .evt0      (evt_v[0]),
    .ev_set0   (ev_set[0]),
    .tick0     (gen_tick[0]),
    .restart0  (mode_v[0].restart),
    .casc      (casc)
);

// File: tb/timer_pair_test.sv
`timescale 1ns/1ps
module timer_pair_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    always #2.5 clk = ~clk;

    timer_pair uut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // behavioural reference state
    int m_cfg;
    int m_mode [2];
    int m_ref  [2];
    int m_cnt  [2];
    int m_evt  [2];
    int m_psr  [2];
    int m_div  [2];
    int m_pc   [2];
    int m_sc   [2];

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic int mread(input int a);
        int g = a >> 1;
        int t = a & 1;
        case (g)
            0: return m_cfg;
            1: return m_mode[t];
            2: return m_ref[t];
            3: return m_cnt[t];
            4: return m_evt[t];
            5: return m_psr[t];
            default: return 0;
        endcase
    endfunction

    function automatic int m_irq();
        int r = 0;
        for (int i = 0; i < 2; i++)
            if (((m_evt[i] >> 1) & 1) == 1 && ((m_mode[i] >> 4) & 1) == 1)
                r |= (1 << i);
        return r;
    endfunction

    task automatic model_reset();
        m_cfg = 0;
        for (int i = 0; i < 2; i++) begin
            m_mode[i] = 0; m_ref[i] = 0; m_cnt[i] = 0; m_evt[i] = 0;
            m_psr[i] = 0;  m_div[i] = 0; m_pc[i] = 0;  m_sc[i] = 0;
        end
    endtask

    task automatic model_step();
        int n_cnt[2], n_evt[2], n_div[2], n_pc[2], n_sc[2];
        bit tk[2], st[2], rb[2], run[2];
        int g, t;
        bit casc, m, z;
        g = bus_addr >> 1;
        t = bus_addr & 1;
        for (int i = 0; i < 2; i++) begin
            int src, sps;
            bit s, p;
            rb[i]  = ((m_cfg >> (i ? 4 : 0)) & 1) == 1;
            run[i] = !(((m_cfg >> (i ? 5 : 1)) & 1) == 1) && !rb[i];
            src = (m_mode[i] >> 1) & 3;
            sps = (m_mode[i] >> 8) & 255;
            s = run[i] && (src == 1 || (src == 2 && m_div[i] == 15));
            p = s && (m_pc[i] == m_psr[i]);
            tk[i] = p && (m_sc[i] == sps);
            n_div[i] = m_div[i];
            if (run[i] && src == 2) n_div[i] = (m_div[i] == 15) ? 0 : m_div[i] + 1;
            n_pc[i] = m_pc[i];
            if (s) n_pc[i] = p ? 0 : ((m_pc[i] + 1) & 255);
            n_sc[i] = m_sc[i];
            if (p) n_sc[i] = tk[i] ? 0 : ((m_sc[i] + 1) & 255);
            n_cnt[i] = m_cnt[i];
            st[i] = 1'b0;
        end
        casc = ((m_mode[1] >> 1) & 3) == 0;
        if (casc) begin
            m = tk[0] && m_cnt[1] == m_ref[1] && m_cnt[0] == m_ref[0];
            z = m && ((m_mode[1] >> 3) & 1) == 1;
            if (z) begin
                n_cnt[0] = 0; n_cnt[1] = 0;
            end else if (tk[0]) begin
                n_cnt[0] = (m_cnt[0] + 1) & 16'hFFFF;
                if (m_cnt[0] == 16'hFFFF && run[1]) n_cnt[1] = (m_cnt[1] + 1) & 16'hFFFF;
            end
            st[1] = m;
        end else begin
            for (int i = 0; i < 2; i++) begin
                m = tk[i] && m_cnt[i] == m_ref[i];
                if (m && ((m_mode[i] >> 3) & 1) == 1) n_cnt[i] = 0;
                else if (tk[i]) n_cnt[i] = (m_cnt[i] + 1) & 16'hFFFF;
                st[i] = m;
            end
        end
        for (int i = 0; i < 2; i++) begin
            int w1c = 0;
            if (bus_we && g == 3 && t == i) n_cnt[i] = bus_wdata;
            if (bus_we && g == 4 && t == i) w1c = bus_wdata & 3;
            n_evt[i] = (m_evt[i] & ~w1c) | (st[i] ? 2 : 0);
            if (rb[i]) begin
                n_cnt[i] = 0; n_evt[i] = 0; n_div[i] = 0; n_pc[i] = 0; n_sc[i] = 0;
            end
        end
        if (bus_we && g == 0) m_cfg = bus_wdata & 255;
        else m_cfg = m_cfg & ~8'h11;
        if (bus_we && g == 1) m_mode[t] = bus_wdata;
        if (bus_we && g == 2) m_ref[t] = bus_wdata;
        if (bus_we && g == 5) m_psr[t] = bus_wdata & 255;
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = n_cnt[i]; m_evt[i] = n_evt[i]; m_div[i] = n_div[i];
            m_pc[i] = n_pc[i];   m_sc[i] = n_sc[i];
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) model_reset();
        else model_step();
        if (cyc > 50000 && !finished) begin
            total++;
            bad++;
            $display("FAIL %s watchdog: actual=%0d cycles expected<=50000", cur_req, cyc);
            finish_up();
        end
    end

    // every-clock comparison, sampled between edges
    always @(posedge clk) begin
        #1.25;
        if (!finished) begin
            check(cur_req, "rdata", int'(bus_rdata), mread(int'(bus_addr)));
            check(cur_req, "irq", int'(irq), m_irq());
        end
    end

    task automatic wr(input int a, input int d);
        bus_we = 1'b1;
        bus_addr = a[3:0];
        bus_wdata = d[15:0];
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic watch(input int a, input int n);
        bus_addr = a[3:0];
        repeat (n) @(negedge clk);
    endtask

    task automatic sweep();
        for (int a = 0; a < 14; a++) watch(a, 1);
    endtask

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        check("R1", "irq after reset", int'(irq), 0);
        sweep();

        cur_req = "R12";
        wr(4, 16'h1234); wr(5, 16'hABCD); wr(10, 16'h005A); wr(11, 16'h00C3);
        wr(12, 16'hFFFF); wr(15, 16'h7777);
        sweep();
        wr(10, 0); wr(11, 0); wr(5, 0);

        cur_req = "R2";
        wr(4, 5); wr(2, 16'h001A);
        watch(6, 20); watch(8, 4);

        cur_req = "R10";
        wr(2, 16'h000A); watch(8, 10);
        wr(2, 16'h001A); watch(8, 3);
        wr(8, 16'h0002); watch(6, 12);

        cur_req = "R3";
        wr(10, 2); wr(4, 3); wr(2, 16'h010A); wr(0, 16'h01);
        watch(6, 50);

        cur_req = "R4";
        wr(10, 0); wr(4, 2); wr(2, 16'h000C); wr(0, 16'h01);
        watch(6, 70);
        wr(2, 16'h0006); watch(6, 10);
        wr(2, 16'h0000); watch(6, 10);

        cur_req = "R5";
        wr(4, 4); wr(2, 16'h0012); wr(0, 16'h01);
        watch(6, 12); watch(8, 3);
        wr(6, 16'hFFFB); watch(6, 10);

        cur_req = "R6";
        wr(3, 16'h000A); wr(5, 100);
        wr(0, 16'h02); watch(6, 10); watch(7, 3);
        wr(0, 16'h00); watch(6, 10);

        cur_req = "R7";
        wr(8, 16'hFFFF); wr(2, 16'h0002); wr(4, 2);
        watch(8, 4);
        wr(0, 16'h01); watch(0, 1); watch(6, 2);
        sweep();
        wr(0, 16'h10); watch(7, 4);

        cur_req = "R8";
        wr(10, 0); wr(4, 3); wr(2, 16'h001A);
        for (int k = 0; k < 8; k++) wr(8, 16'hFFFF);
        watch(8, 6);
        wr(8, 16'h0000); watch(8, 3);

        cur_req = "R9";
        for (int k = 0; k < 6; k++) wr(6, k);
        watch(6, 6);
        wr(7, 16'h0042); watch(7, 4);

        cur_req = "R11";
        wr(2, 16'h0002); wr(4, 3); wr(5, 1);
        wr(3, 16'h0018); wr(0, 16'h11);
        wr(6, 16'hFFF0); watch(7, 18); watch(6, 8);
        sweep();
        wr(9, 16'hFFFF); wr(3, 16'h0010);
        wr(7, 16'h0000); wr(6, 16'hFFFC); watch(7, 10); watch(9, 2);
        wr(0, 16'h20); wr(6, 16'hFFFE); watch(7, 6); watch(6, 2);
        wr(0, 16'h00);
        sweep();

        finish_up();
    end

endmodule